// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the serial-bus slave side of a 1K x 8 nonvolatile memory. It takes the four slave pins (active-low select, serial clock, serial input and active-low pause) and drives serial data out. It decodes byte commands and turns them into requests for the neighbouring units. Array reads use a combinational address/data pair from the array model. Status reads take a live status byte from the protection unit. Write-enable set and clear, status writes and array writes go out as one-cycle request pulses that the protection unit accepts or refuses.

The pins are brought into the system clock domain through synchronizer chains, and edges of the serial clock are detected in that domain. A whole-page buffer is not kept here. Each data byte of an array write is handed to the array's page latch as soon as it completes, together with its final address. A commit or abort pulse follows when select rises. The serial clock may idle low or high, which covers modes 0 and 3. The pause input can freeze a transfer at any bit and later continue it from that bit.

Top module: `spi_ee_front`

## Requirements
- R1: After reset, `so_oe` is low, `so` is low and none of the request pulses (`wren_req`, `wrdi_req`, `sr_wr_req`, `wr_go`, `wr_abort`) is asserted.
- R2: Until `cs_n` has been seen high and then low after reset, no command is decoded, even if a complete byte is shifted in while `cs_n` was already low at reset.
- R3: Opcode 0x06 raises `wren_req` and opcode 0x04 raises `wrdi_req`, each for one cycle, when `cs_n` rises after a whole number of bytes. Bits move MSB first: they are sampled on rising serial clock and shifted out after falling serial clock.
- R4: Opcode 0x02 is followed by a 16-bit address field, of which only the low 10 bits are used, then data bytes. Each completed data byte is staged on `stg_we`/`stg_addr`/`stg_data`. When `cs_n` rises after whole bytes, `wr_go` pulses with `wr_base` equal to the start address and `wr_count` equal to the number of bytes, from 1 to 32.
- R5: During a write, the staging address advances within the current 32-byte page and wraps from the page's last byte to its first.
- R6: An array write whose select rises on a partial byte, or before any data byte, pulses `wr_abort` and never `wr_go`.
- R7: Opcode 0x03 with a 16-bit address field returns consecutive array bytes for as long as select stays low, wrapping from address 0x3FF to 0x000.
- R8: `so_oe` is low during the opcode and address bytes and while deselected. It is high while read data bits are being shifted out.
- R9: With the serial clock idling high (mode 3), reads return the same bytes as with the clock idling low (mode 0).
- R10: Pulling `hold_n` low while the serial clock is low freezes the transfer: clock and input changes are ignored and `so_oe` is low. Raising `hold_n` while the clock is low continues from the exact bit where the pause began.
- R11: While `wip` is high, every opcode except 0x05 is ignored. Opcode 0x05 returns `stat_i` MSB first, including its bit 0 (write in progress), at any time.
- R12: Opcode 0x01 followed by one whole byte pulses `sr_wr_req` at select rise, with `sr_wr_data` equal to that byte.
- R13: Raising `cs_n` discards a partial command, so the next selection starts a fresh opcode. At most one request pulse is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, sampling all serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low slave select |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause |
| so | output | 1 | Serial data out (0 when not enabled) |
| so_oe | output | 1 | Output enable for `so`; low means high impedance |
| mem_addr | output | 10 | Array read address |
| mem_rdata | input | 8 | Array read data for `mem_addr` |
| stat_i | input | 8 | Status byte returned by the status read |
| wip | input | 1 | Internal write cycle in progress |
| wren_req | output | 1 | Pulse: set the write-enable latch |
| wrdi_req | output | 1 | Pulse: clear the write-enable latch |
| sr_wr_req | output | 1 | Pulse: write the status register |
| sr_wr_data | output | 8 | Byte for the status write |
| stg_we | output | 1 | Pulse: one data byte for the page latch |
| stg_addr | output | 10 | Address of the staged byte |
| stg_data | output | 8 | Staged byte |
| wr_go | output | 1 | Pulse: commit the staged page |
| wr_base | output | 10 | Start address of the write |
| wr_count | output | 6 | Number of bytes received, saturating at 32 |
| wr_abort | output | 1 | Pulse: discard the staged bytes |

## Verification
A wrong phase or bit count shows at the ports within one byte. Read data comes back rotated, or `so_oe` rises during an address byte, on the very next falling serial clock. A stale staging offset or byte counter shows only at the end of a write, as a wrong `stg_addr`, `wr_count` or `wr_go`/`wr_abort` choice a few system cycles after select rises. That is why every write is followed by a read-back of its page. A pause that loses or adds one edge shifts every later bit of the transfer, so data is compared across the pause, bit for bit.

// File: rtl/spi_ee_pkg.sv
// Shared opcodes and state encodings for the serial EEPROM command front end.
// Assumes 8-bit opcodes sent MSB first.
package spi_ee_pkg;

    localparam logic [7:0] OP_SET_WE   = 8'h06;
    localparam logic [7:0] OP_CLR_WE   = 8'h04;
    localparam logic [7:0] OP_RD_STAT  = 8'h05;
    localparam logic [7:0] OP_WR_STAT  = 8'h01;
    localparam logic [7:0] OP_RD_ARR   = 8'h03;
    localparam logic [7:0] OP_WR_ARR   = 8'h02;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_RDAT,
        PH_WDAT,
        PH_SDAT,
        PH_SKIP
    } phase_t;

    typedef enum logic [2:0] {
        CM_NONE,
        CM_SETWE,
        CM_CLRWE,
        CM_WRSTAT,
        CM_RDSTAT,
        CM_RDARR,
        CM_WRARR
    } cmd_t;

endpackage

// File: rtl/spi_ee_sync.sv
// Multi-bit synchronizer: each input bit passes through its own flop chain.
// Assumes STAGES >= 2 and that the inputs are independent single-bit levels.
module spi_ee_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES-1:0] chain;

            // Shift the raw pin level one stage deeper every clock.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d[i]};
            end

            assign q[i] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/spi_ee_pause.sv
// Pause latch: enters or leaves pause only while the serial clock is low,
// and is cleared whenever the slave is not selected.
// Assumes synchronized inputs.
module spi_ee_pause (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic sck_s,
    input  logic hold_s,
    output logic paused
);

    // Follow the pause pin only at clock-low moments of a selected transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)      paused <= 1'b0;
        else if (!sel)   paused <= 1'b0;
        else if (!sck_s) paused <= !hold_s;
    end

endmodule

// File: rtl/spi_ee_tx.sv
// Serial output shifter: loads a byte on a falling edge when asked, then
// shifts MSB first on each later falling edge. The enable stays on until
// deselect and is masked while paused.
// Assumes 'fall' is already gated by select and pause.
module spi_ee_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic       fall,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       paused,
    output logic       so,
    output logic       so_oe
);

    logic [7:0] obuf;
    logic       drv;

    // Load or shift the output byte on falling serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n || !sel) begin
            obuf <= '0;
            drv  <= 1'b0;
        end else if (fall) begin
            if (load) begin
                obuf <= din;
                drv  <= 1'b1;
            end else if (drv) begin
                obuf <= {obuf[6:0], 1'b0};
            end
        end
    end

    assign so_oe = drv & ~paused;
    assign so    = so_oe & obuf[7];

endmodule

// File: rtl/spi_ee_front.sv
// Command front end of a serial EEPROM: synchronizes the slave pins, shifts
// bytes MSB first, sequences opcode/address/data phases and issues requests
// to the array and protection units.
// Assumes clk is at least 8x faster than the serial clock.
module spi_ee_front #(
    parameter int ADDR_W      = 10,
    parameter int AFIELD_W    = 16,
    parameter int PAGE_BYTES  = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic [7:0]        stat_i,
    input  logic              wip,
    output logic              wren_req,
    output logic              wrdi_req,
    output logic              sr_wr_req,
    output logic [7:0]        sr_wr_data,
    output logic              stg_we,
    output logic [ADDR_W-1:0] stg_addr,
    output logic [7:0]        stg_data,
    output logic              wr_go,
    output logic [ADDR_W-1:0] wr_base,
    output logic [$clog2(PAGE_BYTES):0] wr_count,
    output logic              wr_abort
);
    import spi_ee_pkg::*;

    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int CNT_W  = PAGE_W + 1;
    localparam int ABYTES = AFIELD_W / 8;
    localparam int AB_W   = $clog2(ABYTES + 1);

    logic cs_s, sck_s, si_s, hold_s;
    logic cs_q, sck_q;
    logic armed, sel, paused;
    logic rise, fall, cs_rise, cs_fall;

    phase_t             phase;
    cmd_t               cmd;
    logic [6:0]         sreg;
    logic [2:0]         bit_cnt;
    logic [AB_W-1:0]    ab_cnt;
    logic [ADDR_W-1:0]  areg, a_next, rd_addr, wbase;
    logic [PAGE_W-1:0]  woff;
    logic [CNT_W-1:0]   nbytes;
    logic               ld_pend, sr_have;
    logic [7:0]         sr_data, nb, tx_byte;

    spi_ee_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hold_n, si, sck, cs_n}),
        .q     ({hold_s, si_s, sck_s, cs_s})
    );

    spi_ee_pause u_pause (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .sck_s  (sck_s),
        .hold_s (hold_s),
        .paused (paused)
    );

    // Previous pin levels for edge detection; select starts "low" so a pin
    // held low through reset does not count as a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q  <= 1'b0;
            sck_q <= 1'b0;
        end else begin
            cs_q  <= cs_s;
            sck_q <= sck_s;
        end
    end

    // Arm on the first observed select falling edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (cs_fall) armed <= 1'b1;
    end

    assign cs_fall = cs_q & ~cs_s;
    assign cs_rise = ~cs_q & cs_s;
    assign sel     = armed & ~cs_s;
    assign rise    = sel & ~paused & sck_s & ~sck_q;
    assign fall    = sel & ~paused & ~sck_s & sck_q;
    assign nb      = {sreg, si_s};
    assign a_next  = ADDR_W'({areg, nb});
    assign tx_byte = (cmd == CM_RDSTAT) ? stat_i : mem_rdata;

    assign mem_addr   = rd_addr;
    assign sr_wr_data = sr_data;
    assign wr_base    = wbase;

    // Command sequencer: byte assembly, phase steps and request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase     <= PH_OPC;
            cmd       <= CM_NONE;
            sreg      <= '0;
            bit_cnt   <= '0;
            ab_cnt    <= '0;
            areg      <= '0;
            rd_addr   <= '0;
            wbase     <= '0;
            woff      <= '0;
            nbytes    <= '0;
            ld_pend   <= 1'b0;
            sr_have   <= 1'b0;
            sr_data   <= '0;
            wren_req  <= 1'b0;
            wrdi_req  <= 1'b0;
            sr_wr_req <= 1'b0;
            stg_we    <= 1'b0;
            stg_addr  <= '0;
            stg_data  <= '0;
            wr_go     <= 1'b0;
            wr_count  <= '0;
            wr_abort  <= 1'b0;
        end else begin
            wren_req  <= 1'b0;
            wrdi_req  <= 1'b0;
            sr_wr_req <= 1'b0;
            stg_we    <= 1'b0;
            wr_go     <= 1'b0;
            wr_abort  <= 1'b0;
            if (!sel) begin
                if (armed && cs_rise) begin
                    if (bit_cnt == 3'd0) begin
                        case (cmd)
                            CM_SETWE:  wren_req  <= 1'b1;
                            CM_CLRWE:  wrdi_req  <= 1'b1;
                            CM_WRSTAT: sr_wr_req <= sr_have;
                            CM_WRARR: begin
                                if (nbytes != '0) begin
                                    wr_go    <= 1'b1;
                                    wr_count <= nbytes;
                                end else begin
                                    wr_abort <= 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end else if (cmd == CM_WRARR) begin
                        wr_abort <= 1'b1;
                    end
                end
                phase   <= PH_OPC;
                cmd     <= CM_NONE;
                bit_cnt <= '0;
                ab_cnt  <= '0;
                nbytes  <= '0;
                ld_pend <= 1'b0;
                sr_have <= 1'b0;
            end else begin
                if (fall) ld_pend <= 1'b0;
                if (rise) begin
                    sreg    <= nb[6:0];
                    bit_cnt <= bit_cnt + 3'd1;
                    if (bit_cnt == 3'd7) begin
                        case (phase)
                            PH_OPC: begin
                                if (wip && nb != OP_RD_STAT) begin
                                    phase <= PH_SKIP;
                                    cmd   <= CM_NONE;
                                end else begin
                                    case (nb)
                                        OP_SET_WE: begin
                                            phase <= PH_SKIP;
                                            cmd   <= CM_SETWE;
                                        end
                                        OP_CLR_WE: begin
                                            phase <= PH_SKIP;
                                            cmd   <= CM_CLRWE;
                                        end
                                        OP_RD_STAT: begin
                                            phase   <= PH_RDAT;
                                            cmd     <= CM_RDSTAT;
                                            ld_pend <= 1'b1;
                                        end
                                        OP_WR_STAT: begin
                                            phase <= PH_SDAT;
                                            cmd   <= CM_WRSTAT;
                                        end
                                        OP_RD_ARR: begin
                                            phase <= PH_ADDR;
                                            cmd   <= CM_RDARR;
                                        end
                                        OP_WR_ARR: begin
                                            phase <= PH_ADDR;
                                            cmd   <= CM_WRARR;
                                        end
                                        default: begin
                                            phase <= PH_SKIP;
                                            cmd   <= CM_NONE;
                                        end
                                    endcase
                                end
                            end
                            PH_ADDR: begin
                                areg   <= a_next;
                                ab_cnt <= ab_cnt + 1'b1;
                                if (ab_cnt == AB_W'(ABYTES - 1)) begin
                                    if (cmd == CM_RDARR) begin
                                        rd_addr <= a_next;
                                        phase   <= PH_RDAT;
                                        ld_pend <= 1'b1;
                                    end else begin
                                        wbase <= a_next;
                                        woff  <= a_next[PAGE_W-1:0];
                                        phase <= PH_WDAT;
                                    end
                                end
                            end
                            PH_RDAT: begin
                                ld_pend <= 1'b1;
                                if (cmd == CM_RDARR) rd_addr <= rd_addr + 1'b1;
                            end
                            PH_WDAT: begin
                                stg_we   <= 1'b1;
                                stg_addr <= {wbase[ADDR_W-1:PAGE_W], woff};
                                stg_data <= nb;
                                woff     <= woff + 1'b1;
                                if (nbytes != CNT_W'(PAGE_BYTES))
                                    nbytes <= nbytes + 1'b1;
                            end
                            PH_SDAT: begin
                                sr_data <= nb;
                                sr_have <= 1'b1;
                                phase   <= PH_SKIP;
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    spi_ee_tx u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .fall   (fall),
        .load   (ld_pend),
        .din    (tx_byte),
        .paused (paused),
        .so     (so),
        .so_oe  (so_oe)
    );

endmodule

// File: rtl/spi_ee_front_chk.sv
// Property checker for the command front end, attached by bind.
// Assumes the internal select, pause and bit-count names of the top.
module spi_ee_front_chk #(
    parameter int CNT_W      = 6,
    parameter int PAGE_BYTES = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sel,
    input logic             paused,
    input logic [2:0]       bit_cnt,
    input logic             so_oe,
    input logic             wren_req,
    input logic             wrdi_req,
    input logic             sr_wr_req,
    input logic             stg_we,
    input logic             wr_go,
    input logic             wr_abort,
    input logic [CNT_W-1:0] wr_count
);

    // R8
    oe_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !so_oe);

    // R10
    pause_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (paused && sel) |=> $stable(bit_cnt));

    // R13
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wren_req, wrdi_req, sr_wr_req, wr_go, wr_abort}));

    // R4
    commit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> (wr_count != '0 && wr_count <= CNT_W'(PAGE_BYTES)));

    // R4
    stage_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stg_we |-> $past(sel));

endmodule

bind spi_ee_front spi_ee_front_chk #(.CNT_W(CNT_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .paused    (paused),
    .bit_cnt   (bit_cnt),
    .so_oe     (so_oe),
    .wren_req  (wren_req),
    .wrdi_req  (wrdi_req),
    .sr_wr_req (sr_wr_req),
    .stg_we    (stg_we),
    .wr_go     (wr_go),
    .wr_abort  (wr_abort),
    .wr_count  (wr_count)
);

// File: tb/spi_ee_front_test.sv
// Directed bench for the command front end: one task per scenario, with
// array, page latch and write-busy models around the design.
module spi_ee_front_test;

    localparam int HALF = 8;
    localparam int BUSY = 4000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b0, sck = 1'b0, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe;
    logic [9:0] mem_addr;
    logic [7:0] mem_rdata, stat_i;
    logic wip = 1'b0;
    logic wren_req, wrdi_req, sr_wr_req, stg_we, wr_go, wr_abort;
    logic [7:0] sr_wr_data, stg_data;
    logic [9:0] stg_addr, wr_base;
    logic [5:0] wr_count;

    always #10 clk = ~clk;

    spi_ee_front uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .stat_i(stat_i), .wip(wip), .wren_req(wren_req), .wrdi_req(wrdi_req),
        .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data), .stg_we(stg_we),
        .stg_addr(stg_addr), .stg_data(stg_data), .wr_go(wr_go), .wr_base(wr_base),
        .wr_count(wr_count), .wr_abort(wr_abort)
    );

    // Environment models: array, page latch, busy timer, status byte.
    logic [7:0] arr [1024];
    logic [7:0] lat [1024];
    logic       latv [1024];
    int busy_cnt = 0;
    int n_wren = 0, n_wrdi = 0, n_srwr = 0, n_go = 0, n_abort = 0, n_pulse_reset = 0;
    logic [7:0] cap_sr;
    logic [9:0] cap_base;
    logic [5:0] cap_cnt;

    assign mem_rdata = arr[mem_addr];
    assign stat_i    = {6'b101000, 1'b0, wip};

    initial begin
        for (int i = 0; i < 1024; i++) begin
            arr[i]  = 8'(i) ^ 8'h5A;
            latv[i] = 1'b0;
            lat[i]  = 8'h00;
        end
    end

    always @(posedge clk) begin
        if (wren_req)  n_wren++;
        if (wrdi_req)  n_wrdi++;
        if (sr_wr_req) begin n_srwr++; cap_sr = sr_wr_data; end
        if (wr_abort) begin
            n_abort++;
            for (int i = 0; i < 1024; i++) latv[i] = 1'b0;
        end
        if (stg_we) begin lat[stg_addr] = stg_data; latv[stg_addr] = 1'b1; end
        if (wr_go) begin
            n_go++; cap_base = wr_base; cap_cnt = wr_count;
            for (int i = 0; i < 1024; i++) if (latv[i]) begin arr[i] = lat[i]; latv[i] = 1'b0; end
            busy_cnt = BUSY;
            wip <= 1'b1;
        end else if (busy_cnt > 0) begin
            busy_cnt--;
            if (busy_cnt == 0) wip <= 1'b0;
        end
    end

    int checks = 0, errors = 0;
    bit mode3 = 1'b0;
    int hold_bit = -1;
    bit oe_any, oe_all, hold_oe;
    logic [7:0] rbuf [8];
    logic [7:0] wbuf [8];
    bit hdr_oe;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel_on();
        sck = mode3; waitc(HALF);
        cs_n = 1'b0; waitc(HALF);
    endtask

    task automatic sel_off();
        cs_n = 1'b1; waitc(4 * HALF);
    endtask

    // Shift one byte; optional pause before bit index hold_bit (mode 0 only).
    task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, input int nbits);
        oe_any = 1'b0; oe_all = 1'b1; rx = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (i == hold_bit) begin
                hold_n = 1'b0; waitc(HALF);
                hold_oe = so_oe;
                for (int k = 0; k < 3; k++) begin
                    si = k[0]; sck = 1'b1; waitc(HALF); sck = 1'b0; waitc(HALF);
                end
                hold_n = 1'b1; waitc(HALF);
            end
            if (mode3) sck = 1'b0;
            si = tx[i]; waitc(HALF);
            rx[i] = so; oe_any |= so_oe; oe_all &= so_oe;
            sck = 1'b1; waitc(HALF);
            if (!mode3) sck = 1'b0;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] rx;
        sel_on(); xbyte(op, rx, 8); sel_off();
    endtask

    task automatic read_arr(input logic [15:0] a, input int n, input int hold_in_data);
        logic [7:0] rx;
        bit h;
        sel_on();
        xbyte(8'h03, rx, 8); h = oe_any;
        xbyte(a[15:8], rx, 8); h |= oe_any;
        xbyte(a[7:0], rx, 8); h |= oe_any;
        hdr_oe = h;
        for (int j = 0; j < n; j++) begin
            hold_bit = (j == 0) ? hold_in_data : -1;
            xbyte(8'h00, rbuf[j], 8);
            hold_bit = -1;
            if (j == 0) h = oe_all; else h &= oe_all;
        end
        oe_all = h;
        sel_off();
    endtask

    task automatic write_arr(input logic [15:0] a, input int n, input int tail_bits);
        logic [7:0] rx;
        sel_on();
        xbyte(8'h02, rx, 8); xbyte(a[15:8], rx, 8); xbyte(a[7:0], rx, 8);
        for (int j = 0; j < n; j++) xbyte(wbuf[j], rx, 8);
        if (tail_bits > 0) xbyte(8'hFF, rx, tail_bits);
        sel_off();
    endtask

    task automatic wait_idle();
        while (wip) @(negedge clk);
        waitc(HALF);
    endtask

    task automatic t_reset();
        check("R1 so_oe after reset", so_oe, 0);
        check("R1 so after reset", so, 0);
        check("R1 no pulse after reset", n_pulse_reset, 0);
    endtask

    task automatic t_powerup();
        logic [7:0] rx;
        xbyte(8'h06, rx, 8);
        sel_off();
        check("R2 unarmed byte ignored", n_wren, 0);
    endtask

    task automatic t_enable();
        logic [7:0] rx;
        cmd1(8'h06);
        check("R3 set-enable pulse", n_wren, 1);
        cmd1(8'h04);
        check("R3 clear-enable pulse", n_wrdi, 1);
        sel_on(); xbyte(8'h06, rx, 5); sel_off();
        check("R13 partial opcode discarded", n_wren, 1);
        cmd1(8'h06);
        check("R13 fresh opcode after discard", n_wren, 2);
    endtask

    task automatic t_write();
        wbuf[0] = 8'hA1; wbuf[1] = 8'hB2; wbuf[2] = 8'hC3;
        write_arr(16'hFD05, 3, 0);
        check("R4 commit count", n_go, 1);
        check("R4 commit base", cap_base, 10'h105);
        check("R4 commit length", cap_cnt, 3);
        wait_idle();
        read_arr(16'h0105, 3, -1);
        check("R4 readback 0", rbuf[0], 8'hA1);
        check("R4 readback 1", rbuf[1], 8'hB2);
        check("R4 readback 2", rbuf[2], 8'hC3);
    endtask

    task automatic t_page_wrap();
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        write_arr(16'h03DE, 4, 0);
        check("R5 wrapped length", cap_cnt, 4);
        wait_idle();
        read_arr(16'h03DE, 2, -1);
        check("R5 page end 0x3DE", rbuf[0], 8'h11);
        check("R5 page end 0x3DF", rbuf[1], 8'h22);
        read_arr(16'h03C0, 3, -1);
        check("R5 wrapped to 0x3C0", rbuf[0], 8'h33);
        check("R5 wrapped to 0x3C1", rbuf[1], 8'h44);
        check("R5 0x3C2 untouched", rbuf[2], 8'hC2 ^ 8'h5A);
        check("R5 0x3E0 untouched", arr[10'h3E0], 8'hE0 ^ 8'h5A);
    endtask

    task automatic t_abort();
        int go0 = n_go, ab0 = n_abort;
        wbuf[0] = 8'hEE;
        write_arr(16'h0010, 1, 3);
        check("R6 abort pulse", n_abort, ab0 + 1);
        check("R6 no commit", n_go, go0);
        read_arr(16'h0010, 1, -1);
        check("R6 array unchanged", rbuf[0], 8'h10 ^ 8'h5A);
    endtask

    task automatic t_read_wrap();
        read_arr(16'hFBFE, 3, -1);
        check("R7 read 0x3FE", rbuf[0], 8'hFE ^ 8'h5A);
        check("R7 read 0x3FF", rbuf[1], 8'hFF ^ 8'h5A);
        check("R7 wrap to 0x000", rbuf[2], 8'h00 ^ 8'h5A);
        check("R8 no drive in header", hdr_oe, 0);
        check("R8 drive during data", oe_all, 1);
    endtask

    task automatic t_mode3();
        mode3 = 1'b1;
        read_arr(16'h0105, 2, -1);
        mode3 = 1'b0;
        check("R9 mode3 byte 0", rbuf[0], 8'hA1);
        check("R9 mode3 byte 1", rbuf[1], 8'hB2);
        check("R9 mode3 header undriven", hdr_oe, 0);
    endtask

    task automatic t_hold();
        logic [7:0] rx;
        sel_on();
        xbyte(8'h03, rx, 8);
        hold_bit = 4;
        xbyte(8'h01, rx, 8);
        hold_bit = -1;
        xbyte(8'h06, rx, 8);
        hold_bit = 3;
        xbyte(8'h00, rbuf[0], 8);
        hold_bit = -1;
        check("R10 output off in pause", hold_oe, 0);
        xbyte(8'h00, rbuf[1], 8);
        sel_off();
        check("R10 byte across pauses", rbuf[0], 8'hB2);
        check("R10 next byte", rbuf[1], 8'hC3);
    endtask

    task automatic t_busy();
        logic [7:0] rx;
        int w0;
        sel_on(); xbyte(8'h05, rx, 8); xbyte(8'h00, rbuf[0], 8); sel_off();
        check("R11 status when idle", rbuf[0], 8'hA0);
        wbuf[0] = 8'h77;
        write_arr(16'h0200, 1, 0);
        sel_on(); xbyte(8'h05, rx, 8); xbyte(8'h00, rbuf[0], 8); sel_off();
        check("R11 status during busy", rbuf[0], 8'hA1);
        read_arr(16'h0105, 2, -1);
        check("R11 read ignored while busy", oe_all, 0);
        w0 = n_wren;
        cmd1(8'h06);
        check("R11 enable ignored while busy", n_wren, w0);
        check("R11 still busy", wip, 1);
        wait_idle();
    endtask

    task automatic t_status_write();
        logic [7:0] rx;
        sel_on(); xbyte(8'h01, rx, 8); xbyte(8'h8C, rx, 8); sel_off();
        check("R12 status write pulse", n_srwr, 1);
        check("R12 status write data", cap_sr, 8'h8C);
        sel_on(); xbyte(8'h01, rx, 8); xbyte(8'h33, rx, 4); sel_off();
        check("R12 partial status byte dropped", n_srwr, 1);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        waitc(5);
        rst_n = 1'b1;
        waitc(4);
        n_pulse_reset = n_wren + n_wrdi + n_srwr + n_go + n_abort;
        t_reset();
        t_powerup();
        t_enable();
        t_write();
        t_page_wrap();
        t_abort();
        t_read_wrap();
        t_mode3();
        t_hold();
        t_busy();
        t_status_write();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule